// File: doc/BRIEF.md
# End-of-Write Status Read Logic

This block sits on the read side of a byte-lane EEPROM-style memory and lets a host find out when an internal programming cycle has finished without any dedicated status pin. It takes the busy flag, the address and the data of the most recent write from the write controller. It also takes the host's chip-select, output-enable and write-enable strobes and the array read data. From these it drives the output data word and a drive enable for each byte lane.

While the write controller reports busy, each enabled lane returns two status bits in place of stored data. Bit 7 of the lane carries the inverse of the written bit 7 when the host reads the address just written. Bit 6 flips each time a fresh read begins on that lane. All other bits, and every bit once busy drops, come straight from the array.

A write that the controller rejects in its protected state turns the inverse-bit status off until the next programming cycle starts. Outputs are registered, so every result appears one clock after the strobes and data that produce it.

Top module: `eow_status_read`

## Requirements
- R1: A lane's drive enable `dout_oe[i]` is 1 in the cycle after one in which `cs_n[i]`=0, `oe_n`=0 and `we_n`=1, and 0 in the cycle after any other combination.
- R2: A lane whose drive enable is 0 shows all zeros on its 8 bits of `dout`.
- R3: When `busy`=0 in the sampling cycle, an enabled lane shows the array byte for that lane unchanged.
- R4: When `busy`=1, `rd_addr` equals `last_addr` and the inverse-bit status is active, bit 7 of an enabled lane (bits 7, 15, 23, 31 of `dout`) is the inverse of the same bit of `last_data`.
- R5: When `busy`=1 and `rd_addr` differs from `last_addr`, bit 7 of an enabled lane is the array bit.
- R6: When `busy`=1, bit 6 of an enabled lane (bits 6, 14, 22, 30 of `dout`) comes from a per-lane toggle flag. The flag inverts in each cycle where that lane's read becomes active after a cycle in which it was not active, and it holds while the read stays active.
- R7: The toggle flag starts at 0 after reset, never changes while `busy`=0, and is not cleared between programming cycles. The first fresh busy read after reset therefore shows 1.
- R8: When `busy`=1, bits 5 to 0 of an enabled lane are the array bits.
- R9: A one-cycle `wr_reject` pulse turns off the inverse-bit status from the next cycle on. A rising edge of `busy` turns it back on from the next cycle on. If both happen in the same cycle, `wr_reject` wins. While it is off, bit 7 of an enabled busy lane is the array bit.
- R10: During reset, `dout` and `dout_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | LANES | Per-lane chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Programming cycle in progress |
| wr_reject | input | 1 | One-cycle pulse: a protected write was refused |
| last_addr | input | ADDR_W | Address of the most recent write |
| last_data | input | LANES*8 | Data of the most recent write |
| rd_addr | input | ADDR_W | Host read address |
| array_rdata | input | LANES*8 | Array read data |
| dout | output | LANES*8 | Registered output data |
| dout_oe | output | LANES | Registered per-lane drive enable |

## Verification
The assertions assume that all strobes and data are synchronous to `clk` and hold steady across each rising edge. They also assume that `wr_reject` is a single-cycle pulse and that `last_addr` and `last_data` stay stable while `busy` is high.

The stimulus changes inputs only on falling edges. It keeps `busy` in multi-cycle phases and loads fresh `last_*` values only while `busy` is low. It fires `wr_reject` as isolated pulses, and it points about half of all reads at the last written address, so that both R4 and R5 get plenty of traffic.

// File: rtl/eow_pkg.sv
package eow_pkg;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned POLL_IX = 7;
    localparam int unsigned TOG_IX  = 6;

    typedef struct packed {
        logic              act;
        logic              tog;
        logic              en;
        logic [LANE_W-1:0] data;
    } lane_reg_t;

    typedef struct packed {
        logic busy;
        logic inhib;
    } poll_reg_t;
endpackage

// File: rtl/eow_read_qual.sv
module eow_read_qual #(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES-1:0] cs_n,
    input  logic             oe_n,
    input  logic             we_n,
    output logic [LANES-1:0] rd_act
);
    for (genvar g = 0; g < LANES; g++) begin : g_qual
        assign rd_act[g] = ~cs_n[g] & ~oe_n & we_n;
    end
endmodule

// File: rtl/eow_poll_ctrl.sv
module eow_poll_ctrl #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_reject,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              cmp_en
);
    import eow_pkg::*;

    poll_reg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = busy;
        if (wr_reject)
            st_d.inhib = 1'b1;
        else if (busy && !st_q.busy)
            st_d.inhib = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_en = busy && (rd_addr == last_addr) && !st_q.inhib;

    // R9
    reject_sets_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |=> !cmp_en);
    // R9
    busy_rise_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !st_q.busy && !wr_reject) ##1 (busy && rd_addr == last_addr) |-> cmp_en);
endmodule

// File: rtl/eow_lane.sv
module eow_lane
    import eow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  logic              busy,
    input  logic              cmp_en,
    input  logic              last_bit7,
    input  logic [LANE_W-1:0] array_lane,
    output logic [LANE_W-1:0] dout_lane,
    output logic              dout_en
);
    lane_reg_t r_d, r_q;
    logic      new_rd;

    always_comb begin
        r_d    = r_q;
        new_rd = rd_act && !r_q.act;
        r_d.act = rd_act;
        r_d.en  = rd_act;
        r_d.tog = r_q.tog ^ (busy && new_rd);
        if (!rd_act) begin
            r_d.data = '0;
        end else if (!busy) begin
            r_d.data = array_lane;
        end else begin
            r_d.data          = array_lane;
            r_d.data[TOG_IX]  = r_d.tog;
            r_d.data[POLL_IX] = cmp_en ? ~last_bit7 : array_lane[POLL_IX];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout_lane = r_q.data;
    assign dout_en   = r_q.en;

    // R1
    oe_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> dout_en);
    // R2
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> (dout_lane == '0 && !dout_en));
    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !busy) |=> dout_lane == $past(array_lane));
    // R4
    poll_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && busy && cmp_en) |=> dout_lane[POLL_IX] == !$past(last_bit7));
    // R6
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !r_q.act && busy) |=> r_q.tog != $past(r_q.tog));
    // R7
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(r_q.tog));
endmodule

// File: rtl/eow_status_read.sv
module eow_status_read #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned ADDR_W = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         cs_n,
    input  logic                     oe_n,
    input  logic                     we_n,
    input  logic                     busy,
    input  logic                     wr_reject,
    input  logic [ADDR_W-1:0]        last_addr,
    input  logic [LANES*8-1:0]       last_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [LANES*8-1:0]       array_rdata,
    output logic [LANES*8-1:0]       dout,
    output logic [LANES-1:0]         dout_oe
);
    import eow_pkg::*;
    localparam int unsigned DW = LANES * LANE_W;

    logic [LANES-1:0] rd_act;
    logic             cmp_en;

    eow_read_qual #(.LANES(LANES)) qual_i (
        .cs_n  (cs_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .rd_act(rd_act)
    );

    eow_poll_ctrl #(.ADDR_W(ADDR_W)) poll_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .wr_reject(wr_reject),
        .last_addr(last_addr),
        .rd_addr  (rd_addr),
        .cmp_en   (cmp_en)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        eow_lane lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_act    (rd_act[g]),
            .busy      (busy),
            .cmp_en    (cmp_en),
            .last_bit7 (last_data[g*LANE_W+POLL_IX]),
            .array_lane(array_rdata[g*LANE_W +: LANE_W]),
            .dout_lane (dout[g*LANE_W +: LANE_W]),
            .dout_en   (dout_oe[g])
        );
    end

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == {DW{1'b0}} && dout_oe == '0));
endmodule

// File: tb/eow_status_read_tb_top.sv
module eow_status_read_tb_top;
    localparam int LANES = 4;
    localparam int AW    = 15;
    localparam int DW    = LANES * 8;

    logic clk = 1'b0;
    logic rst_n;
    logic [LANES-1:0] cs_n;
    logic oe_n, we_n, busy, wr_reject;
    logic [AW-1:0] last_addr, rd_addr;
    logic [DW-1:0] last_data, array_rdata, dout;
    logic [LANES-1:0] dout_oe;

    always #2 clk = ~clk;

    eow_status_read #(.LANES(LANES), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .wr_reject(wr_reject), .last_addr(last_addr),
        .last_data(last_data), .rd_addr(rd_addr), .array_rdata(array_rdata),
        .dout(dout), .dout_oe(dout_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic done = 1'b0;

    // model state
    logic [LANES-1:0] m_pact, m_tog;
    logic m_inh, m_pbusy;
    logic [DW-1:0] e_dout;
    logic [LANES-1:0] e_oe;
    logic e_busy, e_inh, e_match;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] lane_exp(input logic act, input logic bsy, input logic cmp,
                                            input logic lb7, input logic tg, input logic [7:0] arr);
        logic [7:0] v;
        if (!act) return 8'h00;
        v = arr;
        if (bsy) begin
            v[6] = tg;
            v[7] = cmp ? ~lb7 : arr[7];
        end
        return v;
    endfunction

    // compute expected outputs for inputs currently applied, advance model
    task automatic model_step();
        logic cmp;
        e_busy  = busy;
        e_inh   = m_inh;
        e_match = (rd_addr == last_addr);
        cmp = busy && e_match && !m_inh;
        for (int i = 0; i < LANES; i++) begin
            logic act;
            act = !cs_n[i] && !oe_n && we_n;
            if (busy && act && !m_pact[i]) m_tog[i] = ~m_tog[i];
            e_oe[i] = act;
            e_dout[i*8 +: 8] = lane_exp(act, busy, cmp, last_data[i*8+7], m_tog[i],
                                        array_rdata[i*8 +: 8]);
            m_pact[i] = act;
        end
        if (wr_reject) m_inh = 1'b1;
        else if (busy && !m_pbusy) m_inh = 1'b0;
        m_pbusy = busy;
    endtask

    task automatic compare_out(input string dtag);
        for (int i = 0; i < LANES; i++) begin
            chk("R1", 32'(dout_oe[i]), 32'(e_oe[i]));
            if (!e_oe[i])
                chk("R2", 32'(dout[i*8 +: 8]), 32'(e_dout[i*8 +: 8]));
            else if (!e_busy)
                chk("R3", 32'(dout[i*8 +: 8]), 32'(e_dout[i*8 +: 8]));
            else begin
                if (!e_match)      chk("R5", 32'(dout[i*8+7]), 32'(e_dout[i*8+7]));
                else if (e_inh)    chk("R9", 32'(dout[i*8+7]), 32'(e_dout[i*8+7]));
                else               chk("R4", 32'(dout[i*8+7]), 32'(e_dout[i*8+7]));
                chk(dtag, 32'(dout[i*8+6]), 32'(e_dout[i*8+6]));
                chk("R8", 32'(dout[i*8 +: 6]), 32'(e_dout[i*8 +: 6]));
            end
        end
    endtask

    task automatic cycle(input string dtag);
        model_step();
        @(posedge clk); #1;
        compare_out(dtag);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cs_n = '1; oe_n = 1'b1; we_n = 1'b1; wr_reject = 1'b0;
    endtask

    task automatic read_all(input logic [AW-1:0] a);
        cs_n = '0; oe_n = 1'b0; we_n = 1'b1; rd_addr = a;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; busy = 1'b0; idle_inputs();
        last_addr = 15'h1234; last_data = 32'h8080_0080;
        rd_addr = '0; array_rdata = 32'hFFFF_FFFF;
        m_pact = '0; m_tog = '0; m_inh = 1'b0; m_pbusy = 1'b0;
        read_all(15'h1234);   // strobes active during reset must not leak
        repeat (3) @(posedge clk);
        #1;
        chk("R10", dout, 32'h0);
        chk("R10", 32'(dout_oe), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_inputs();

        // directed: first busy read after reset shows bit6 = 1 (R7)
        busy = 1'b1; cycle("R6");
        array_rdata = 32'h0000_0000;
        read_all(15'h1234); cycle("R7");
        if (dout[6] !== 1'b1) begin n_bad++; $display("FAIL R7: actual %0b expected 1", dout[6]); end
        n_cmp++;
        cycle("R6");             // held read: no flip
        idle_inputs(); cycle("R6");
        read_all(15'h1234); cycle("R6");  // flips to 0
        // toggling via OE only, CS held
        oe_n = 1'b1; cycle("R6");
        oe_n = 1'b0; cycle("R6");
        // end write, toggle must stay put (R7)
        idle_inputs(); busy = 1'b0; cycle("R7");
        read_all(15'h1234); array_rdata = 32'hA5C3_3C5A; cycle("R7");
        idle_inputs(); cycle("R7");
        // new write, state carried over
        busy = 1'b1; cycle("R7");
        read_all(15'h1234); cycle("R7");

        // directed R9: reject during busy suppresses inverse bit
        idle_inputs(); wr_reject = 1'b1; cycle("R6");
        wr_reject = 1'b0; read_all(15'h1234); cycle("R6");
        cycle("R6");
        idle_inputs(); busy = 1'b0; cycle("R6");
        busy = 1'b1; wr_reject = 1'b1; cycle("R6");   // same cycle: reject wins
        wr_reject = 1'b0; read_all(15'h1234); cycle("R6");
        idle_inputs(); busy = 1'b0; cycle("R6");
        busy = 1'b1; cycle("R6");                     // rise re-enables
        read_all(15'h1234); cycle("R6");
        idle_inputs(); busy = 1'b0; cycle("R6");

        // constrained random
        for (int ph = 0; ph < 120; ph++) begin
            int len;
            if (!busy) begin
                last_addr = 15'($urandom);
                last_data = $urandom;
            end
            busy = ~busy;
            len = 5 + ($urandom % 20);
            for (int k = 0; k < len; k++) begin
                for (int i = 0; i < LANES; i++) cs_n[i] = ($urandom % 4) == 0;
                oe_n = ($urandom % 3) == 0;
                we_n = ($urandom % 8) != 0;
                wr_reject = ($urandom % 40) == 0;
                rd_addr = ($urandom % 2) ? last_addr : 15'($urandom);
                array_rdata = $urandom;
                cycle("R6");
                wr_reject = 1'b0;
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule